// File: doc/BRIEF.md
# Serial-Loaded PHY Tuning Cell Bank

This block holds the tuning bits of up to three transceivers. Each transceiver has 256 single-bit cells. Software cannot write the cells directly. It loads them one bit at a time through a shared 32-bit control word. Software puts a cell address and a data bit into that word, then raises the strobe bit of the target transceiver. Each 0-to-1 change of a strobe bit commits one cell. The usual sequence is: clear the strobe, set it, clear it again. Every cell is a flop, and all arrays drive the output in parallel, so the analog side sees a steady value with no further access needed.

The bus side is a bank of four 32-bit words selected by a 2-bit word index; byte offset = 4 × index. A transfer is either a full word or the low byte only. Word 1 (offset 0x04) is the control word. Words 0, 2 and 3 are plain storage. Two cell addresses hold settings shared by every transceiver. A commit to either of them, through any strobe, writes that cell in every array.

Top module: `phy_tune_bank`

## Requirements
- R1: After a synchronous reset every bank word, every tuning cell and `bus_rdata` are zero.
- R2: A word write stores all 32 bits of the selected word. A read request in one cycle presents that word on `bus_rdata` after the next clock edge, and `bus_rdata` keeps its value when no read is requested.
- R3: A byte write (`bus_word` = 0) replaces bits [7:0] of the selected word and keeps bits [31:8].
- R4: When a write makes bit 2·n of the control word (index 1) go from 0 to 1, cell A of transceiver n takes bit 7 of the new word, where A = bits [15:8] of the new word. Cell A of transceiver n is output bit n·256 + A of `tune_cells`, and it changes at the same clock edge as the word.
- R5: A write that leaves a strobe bit at 1 or takes it from 1 to 0 commits nothing, even if it changes the address or data field.
- R6: When strobe bits of several transceivers rise in the same write, each of those transceivers commits the same address and data.
- R7: A commit to cell address 0x03 or 0x0C writes that cell in every transceiver, whichever strobe rose.
- R8: Writes to words 0, 2 and 3 never change any tuning cell, whatever bit pattern they carry.
- R9: A byte write alone can commit a cell: its strobe edge uses the address field already held in bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_word | input | 1 | 1 = full-word transfer, 0 = low byte only |
| bus_sel | input | 2 | Word index (byte offset = 4 × index) |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request for this cycle |
| bus_rdata | output | 32 | Registered read data |
| tune_cells | output | NUM_PHYS·256 | All tuning cells; transceiver n occupies bits n·256 + 255 down to n·256 |

## Verification
A write and the cell commit it causes both take effect at the clock edge that samples the request. A read result appears after the edge that samples the read. So every result is due one edge after its stimulus. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It then compares `bus_rdata` and every transceiver array at the next falling edge, in every cycle. An early or late commit, a missing commit or a wrong routing of a shared address is therefore seen in the cycle it happens.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;
  localparam int BUS_W      = 32;
  localparam int SEL_W      = 2;
  localparam int NUM_WORDS  = 1 << SEL_W;
  localparam logic [SEL_W-1:0] CTRL_SEL = 2'd1;
  // field positions inside the control word
  localparam int DATA_POS   = 7;
  localparam int ADDR_LSB   = 8;
  localparam int CELL_AW    = 8;
  localparam int CELLS      = 1 << CELL_AW;
  typedef logic [CELL_AW-1:0] cell_addr_t;
endpackage

// File: rtl/phy_tune_regs.sv
module phy_tune_regs
  import phy_tune_pkg::*;
#(
  parameter int NUM_PHYS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_word,
  input  logic [SEL_W-1:0]     bus_sel,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_rd,
  output logic [BUS_W-1:0]     bus_rdata,
  output logic [NUM_PHYS-1:0]  commit,
  output cell_addr_t           commit_addr,
  output logic                 commit_bit
);
  logic [BUS_W-1:0] words_q [NUM_WORDS];
  logic [BUS_W-1:0] merged;
  logic             ctrl_hit;

  assign merged   = bus_word ? bus_wdata
                             : {words_q[bus_sel][BUS_W-1:8], bus_wdata[7:0]};
  assign ctrl_hit = bus_wr && (bus_sel == CTRL_SEL);

  assign commit_addr = merged[ADDR_LSB +: CELL_AW];
  assign commit_bit  = merged[DATA_POS];

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_edge
    assign commit[n] = ctrl_hit && merged[2*n] && !words_q[CTRL_SEL][2*n];

    AST_COMMIT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
      commit[n] |=> words_q[CTRL_SEL][2*n]);  // R5
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_rd) bus_rdata <= words_q[bus_sel];
      if (bus_wr) words_q[bus_sel] <= merged;
    end
  end

  AST_BYTE_KEEPS_UPPER: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_word) |=> words_q[$past(bus_sel)][BUS_W-1:8] == $past(words_q[bus_sel][BUS_W-1:8]));  // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));  // R2
  AST_OTHER_WORDS_INERT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_sel != CTRL_SEL) |-> commit == '0);  // R8
endmodule

// File: rtl/phy_tune_route.sv
module phy_tune_route
  import phy_tune_pkg::*;
#(
  parameter int         NUM_PHYS  = 3,
  parameter cell_addr_t SHARED_A  = 8'h03,
  parameter cell_addr_t SHARED_B  = 8'h0C
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PHYS-1:0]  commit,
  input  cell_addr_t           commit_addr,
  output logic [NUM_PHYS-1:0]  cell_we
);
  logic shared_cell;

  assign shared_cell = (commit_addr == SHARED_A) || (commit_addr == SHARED_B);
  assign cell_we     = shared_cell ? {NUM_PHYS{|commit}} : commit;

  AST_SHARED_TO_ALL: assert property (@(posedge clk) disable iff (rst)
    (shared_cell && commit != '0) |-> &cell_we);  // R7
  AST_PRIVATE_ONLY_OWN: assert property (@(posedge clk) disable iff (rst)
    !shared_cell |-> (cell_we & ~commit) == '0);  // R4
endmodule

// File: rtl/phy_tune_cells.sv
module phy_tune_cells
  import phy_tune_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  cell_addr_t        addr,
  input  logic              din,
  output logic [CELLS-1:0]  cells
);
  always_ff @(posedge clk) begin
    if (rst)     cells <= '0;
    else if (we) cells[addr] <= din;
  end

  AST_CELLS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cells));  // R5
  AST_ONE_CELL_PER_EDGE: assert property (@(posedge clk) disable iff (rst)
    we |=> $countones(cells ^ $past(cells)) <= 1);  // R4
endmodule

// File: rtl/phy_tune_bank.sv
module phy_tune_bank
  import phy_tune_pkg::*;
#(
  parameter int NUM_PHYS = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_word,
  input  logic [1:0]                 bus_sel,
  input  logic [31:0]                bus_wdata,
  input  logic                       bus_rd,
  output logic [31:0]                bus_rdata,
  output logic [NUM_PHYS*256-1:0]    tune_cells
);
  logic [NUM_PHYS-1:0] commit;
  logic [NUM_PHYS-1:0] cell_we;
  cell_addr_t          commit_addr;
  logic                commit_bit;

  phy_tune_regs #(.NUM_PHYS(NUM_PHYS)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .commit(commit), .commit_addr(commit_addr),
    .commit_bit(commit_bit)
  );

  phy_tune_route #(.NUM_PHYS(NUM_PHYS)) u_route (
    .clk(clk), .rst(rst), .commit(commit), .commit_addr(commit_addr),
    .cell_we(cell_we)
  );

  for (genvar n = 0; n < NUM_PHYS; n++) begin : g_phy
    phy_tune_cells u_cells (
      .clk(clk), .rst(rst), .we(cell_we[n]), .addr(commit_addr),
      .din(commit_bit), .cells(tune_cells[n*CELLS +: CELLS])
    );
  end
endmodule

// File: tb/tb_phy_tune_bank.sv
module tb_phy_tune_bank;
  localparam int NP = 3;
  localparam int NC = 256;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_word = 0, bus_rd = 0;
  logic [1:0] bus_sel = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NP*NC-1:0] tune_cells;

  int vectors = 0, miscompares = 0;

  logic [31:0]      m_words [4];
  logic [31:0]      m_rdata;
  logic [NP*NC-1:0] m_cells;

  phy_tune_bank #(.NUM_PHYS(NP)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .tune_cells(tune_cells)
  );

  always #10 clk = ~clk;

  task automatic compare(input string tag);
    vectors++;
    if (bus_rdata !== m_rdata) begin
      miscompares++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, m_rdata);
    end
    for (int n = 0; n < NP; n++)
      if (tune_cells[n*NC +: NC] !== m_cells[n*NC +: NC]) begin
        miscompares++;
        $display("FAIL %s phy%0d cells actual=%h expected=%h", tag, n,
                 tune_cells[n*NC +: NC], m_cells[n*NC +: NC]);
      end
  endtask

  // one clock: drive at falling edge, model at rising edge, check at next falling edge
  task automatic step(input bit wr, input bit word, input logic [1:0] sel,
                      input logic [31:0] d, input bit rd, input string tag);
    logic [31:0] nv;
    logic [31:0] old;
    int a;
    bus_wr = wr; bus_word = word; bus_sel = sel; bus_wdata = d; bus_rd = rd;
    @(posedge clk);
    if (rd) m_rdata = m_words[sel];
    if (wr) begin
      old = m_words[sel];
      nv  = word ? d : {old[31:8], d[7:0]};
      if (sel == 2'd1)
        for (int n = 0; n < NP; n++)
          if (nv[2*n] && !old[2*n]) begin
            a = int'(nv[15:8]);
            if (a == 3 || a == 12)
              for (int k = 0; k < NP; k++) m_cells[k*NC + a] = nv[7];
            else
              m_cells[n*NC + a] = nv[7];
          end
      m_words[sel] = nv;
    end
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    compare(tag);
  endtask

  task automatic poke(input int phy, input logic [7:0] a, input bit b, input string tag);
    logic [31:0] base;
    base = {16'h0, a, b, 7'h0};
    step(1, 1, 2'd1, base, 0, tag);
    step(1, 1, 2'd1, base | (32'h1 << (2*phy)), 0, tag);
    step(1, 1, 2'd1, base, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) m_words[i] = '0;
    m_rdata = '0;
    m_cells = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1 reset");
    for (int i = 0; i < 4; i++) step(0, 0, 2'(i), 0, 1, "R1 reset read");

    // R2 word write and readback, strobe bits stay low
    step(1, 1, 2'd1, 32'hDEAD_BE00, 0, "R2 word write");
    step(0, 0, 2'd1, 0, 1, "R2 readback");
    step(0, 0, 2'd0, 0, 0, "R2 rdata hold");

    // R3/R9/R6: byte write raises strobes 0,2,4 with address 0xBE held above
    step(1, 0, 2'd1, 32'hFFFF_FFF7, 0, "R9 byte strobe commit");
    step(0, 0, 2'd1, 0, 1, "R3 byte keeps upper");

    // R5: strobes held high while address and data move, then fall
    step(1, 1, 2'd1, 32'h0000_4015, 0, "R5 level no commit");
    step(1, 1, 2'd1, 32'h0000_4195, 0, "R5 level no commit data");
    step(1, 1, 2'd1, 32'h0000_4180, 0, "R5 falling no commit");

    // R4 private cells in each transceiver
    poke(0, 8'h20, 1, "R4 phy0 0x20");
    poke(1, 8'h22, 1, "R4 phy1 0x22");
    poke(2, 8'h2A, 1, "R4 phy2 0x2A");
    poke(1, 8'hFF, 1, "R4 phy1 top cell");
    poke(0, 8'h00, 1, "R4 phy0 cell 0");
    poke(2, 8'h2A, 0, "R4 phy2 clear");
    poke(1, 8'hBE, 0, "R4 phy1 clear shared-free");

    // R7 shared cells
    poke(1, 8'h03, 1, "R7 shared 0x03 via phy1");
    poke(2, 8'h0C, 1, "R7 shared 0x0C via phy2");
    poke(0, 8'h03, 0, "R7 shared clear via phy0");

    // R6 two strobes in one write
    step(1, 1, 2'd1, 32'h0000_5580, 0, "R6 setup");
    step(1, 1, 2'd1, 32'h0000_5591, 0, "R6 dual commit");
    step(1, 1, 2'd1, 32'h0000_0000, 0, "R6 clear");

    // R8 other words are plain storage
    step(1, 1, 2'd0, 32'hFFFF_FFFF, 0, "R8 word0 write");
    step(1, 1, 2'd2, 32'h0000_FF95, 0, "R8 word2 write");
    step(1, 1, 2'd3, 32'h1234_5678, 0, "R8 word3 write");
    step(1, 0, 2'd2, 32'hAAAA_AA3F, 0, "R3 byte write word2");
    for (int i = 0; i < 4; i++) step(0, 0, 2'(i), 0, 1, "R8 readback");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule